// File: doc/BRIEF.md
# Infrared Carrier Modulator

This block drives an infrared emitter pin from the main clock. A free-running divider splits the clock into twelve-cycle carrier periods. Each period opens with a high phase that lasts either half of the period or a third of it, as software selects. Software handles pulse-code framing and key scanning. It controls the pin through two writes: a 4-bit control word and a single output-latch bit.

The control word carries two bits that matter. Bit 3 selects the duty: 1 gives 1/2 and 0 gives 1/3. Bit 2 opens the carrier path when it is 1. The output latch sets the pin level. With the latch at 0, the pin is held low. With the latch at 1 and the carrier path open, the pin shows the carrier. With the latch at 1 and the path closed, the pin is a steady high, which suits an indicator. When the latch rises, the divider restarts at zero, so the first carrier pulse always has its full width.

Top module: `irc_modulator`

## Requirements
- R1: After an asynchronous reset (rst_n low), ir_o is 0 and stays 0 until the latch is written to 1.
- R2: With the latch at 1 and the carrier enabled, ir_o repeats with a period of exactly 12 clock cycles.
- R3: When control bit 3 is 1, ir_o is high for 6 consecutive cycles out of each 12, starting at divider count 0.
- R4: When control bit 3 is 0, ir_o is high for 4 consecutive cycles out of each 12, starting at divider count 0.
- R5: When control bit 2 is 0 and the latch is 1, ir_o is a steady high.
- R6: While the latch is 0, ir_o is 0 whatever the control bits hold.
- R7: A latch write that takes the latch from 0 to 1 restarts the divider at count 0. ir_o is high from the first cycle after that write, for a full high phase.
- R8: Reset clears both control bits, which gives 1/3 duty with the carrier path closed. A latch of 1 written after reset with no control write gives a steady high.
- R9: A control write does not restart the divider, and neither does a latch write of 1 while the latch is already 1. The carrier phase carries on unbroken.
- R10: A control write takes effect from the cycle after it. The new duty applies to the divider count that is running at that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wd | input | 4 | Control word; bit 3 is the duty select, bit 2 is the carrier enable |
| out_we | input | 1 | Output latch write strobe |
| out_d | input | 1 | Output latch data |
| ir_o | output | 1 | Modulated emitter drive |

## Verification
Directed passes count the high cycles in one period at each duty and measure the period. These passes separate a 6-of-12 pulse from a 4-of-12 pulse, and a divide-by-12 from an off-by-one divider. The latch is raised in the middle of a running period to show that the divider restarts at zero rather than running on. Latch rewrites and control writes are issued mid-pulse to show that the phase is kept, and the closed path is exercised to separate a steady high from a gated low. Random writes of both registers then compare every cycle against a bench model of the pin.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int unsigned IRC_DIV      = 12;
  localparam int unsigned IRC_HALF_HI  = 6;
  localparam int unsigned IRC_THIRD_HI = 4;
  localparam int unsigned IRC_CNT_W    = $clog2(IRC_DIV);

  typedef logic [IRC_CNT_W-1:0] irc_cnt_t;

  typedef struct packed {
    logic half_duty;
    logic car_en;
  } irc_ctl_t;

  function automatic irc_cnt_t irc_next(input irc_cnt_t c);
    return (c == irc_cnt_t'(IRC_DIV - 1)) ? '0 : c + 1'b1;
  endfunction

  function automatic logic irc_in_high(input irc_cnt_t c, input logic half);
    return half ? (c < irc_cnt_t'(IRC_HALF_HI)) : (c < irc_cnt_t'(IRC_THIRD_HI));
  endfunction
endpackage

// File: rtl/irc_divider.sv
module irc_divider
  import irc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     restart,
  output irc_cnt_t cnt,
  output logic     wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else              cnt <= irc_next(cnt);
  end

  assign wrap = (cnt == irc_cnt_t'(IRC_DIV - 1));
endmodule

// File: rtl/irc_regs.sv
module irc_regs
  import irc_pkg::*;
#(
  parameter int unsigned CTL_W    = 4,
  parameter int unsigned HALF_BIT = 3,
  parameter int unsigned EN_BIT   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wd,
  input  logic             out_we,
  input  logic             out_d,
  output irc_ctl_t         ctl,
  output logic             lat,
  output logic             lat_rise
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (ctl_we) begin
      ctl.half_duty <= ctl_wd[HALF_BIT];
      ctl.car_en    <= ctl_wd[EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat <= 1'b0;
    else if (out_we) lat <= out_d;
  end

  assign lat_rise = out_we & out_d & ~lat;
endmodule

// File: rtl/irc_shaper.sv
module irc_shaper
  import irc_pkg::*;
(
  input  irc_cnt_t cnt,
  input  irc_ctl_t ctl,
  input  logic     lat,
  output logic     carrier,
  output logic     pin
);
  always_comb begin
    carrier = irc_in_high(cnt, ctl.half_duty);
    pin     = lat & (ctl.car_en ? carrier : 1'b1);
  end
endmodule

// File: rtl/irc_modulator.sv
module irc_modulator
  import irc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [3:0] ctl_wd,
  input  logic       out_we,
  input  logic       out_d,
  output logic       ir_o
);
  irc_ctl_t ctl;
  irc_cnt_t div_cnt;
  logic     div_wrap;
  logic     lat_q;
  logic     lat_rise;
  logic     carrier;
  logic     duty_half;
  logic     car_en;

  irc_regs #(.CTL_W(4), .HALF_BIT(3), .EN_BIT(2)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wd(ctl_wd),
    .out_we(out_we), .out_d(out_d), .ctl(ctl), .lat(lat_q), .lat_rise(lat_rise)
  );

  irc_divider u_div (
    .clk(clk), .rst_n(rst_n), .restart(lat_rise), .cnt(div_cnt), .wrap(div_wrap)
  );

  irc_shaper u_shape (
    .cnt(div_cnt), .ctl(ctl), .lat(lat_q), .carrier(carrier), .pin(ir_o)
  );

  assign duty_half = ctl.half_duty;
  assign car_en    = ctl.car_en;
endmodule

// File: rtl/irc_modulator_chk.sv
module irc_modulator_chk
  import irc_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     lat,
  input logic     en,
  input logic     half,
  input irc_cnt_t cnt,
  input logic     wrap,
  input logic     ir
);
  AST_LOW_WHEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) !lat |-> !ir); // R6
  AST_STEADY_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_n) (lat && !en) |-> ir); // R5
  AST_RESTART_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(lat) |-> (cnt == '0)); // R7
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n) wrap |=> (cnt == '0)); // R2
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt < irc_cnt_t'(IRC_DIV)); // R2
  AST_HALF_LAST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (lat && en && half && cnt == irc_cnt_t'(IRC_HALF_HI - 1)) |-> ir); // R3
  AST_HALF_FIRST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (lat && en && half && cnt == irc_cnt_t'(IRC_HALF_HI)) |-> !ir); // R3
  AST_THIRD_FIRST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (lat && en && !half && cnt == irc_cnt_t'(IRC_THIRD_HI)) |-> !ir); // R4
endmodule

bind irc_modulator irc_modulator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lat(lat_q), .en(car_en), .half(duty_half),
  .cnt(div_cnt), .wrap(div_wrap), .ir(ir_o)
);

// File: tb/irc_modulator_tb.sv
`timescale 1ns/1ps
module irc_modulator_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [3:0] ctl_wd = 4'h0;
  logic       out_we = 1'b0;
  logic       out_d = 1'b0;
  logic       ir_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench reference state
  int  m_phase = 0;
  bit  m_lat = 0, m_en = 0, m_half = 0;

  always #4 clk = ~clk;

  irc_modulator u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wd(ctl_wd),
    .out_we(out_we), .out_d(out_d), .ir_o(ir_o)
  );

  function automatic bit want_pin(bit l, bit e, bit h, int ph);
    int hi_len;
    hi_len = h ? 12 / 2 : 12 / 3;
    if (!l) return 1'b0;
    if (!e) return 1'b1;
    return ph < hi_len;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= 0; m_lat <= 0; m_en <= 0; m_half <= 0;
    end else begin
      if (ctl_we) begin m_half <= ctl_wd[3]; m_en <= ctl_wd[2]; end
      if (out_we) m_lat <= out_d;
      if (out_we && out_d && !m_lat) m_phase <= 0;
      else m_phase <= (m_phase + 1) % 12;
    end
  end

  task automatic check(input string tag, input bit act, input bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: ir_o=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_model();
    string tag;
    if (!m_lat) tag = "R6";
    else if (!m_en) tag = "R5";
    else if (m_half) tag = "R3 R2";
    else tag = "R4 R2";
    check(tag, ir_o, want_pin(m_lat, m_en, m_half, m_phase));
  endtask

  task automatic wr_ctl(input logic [3:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wd = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_lat(input logic v);
    @(negedge clk); out_we = 1'b1; out_d = v;
    @(negedge clk); out_we = 1'b0;
  endtask

  // counts highs across one period starting right after a latch rise
  task automatic pulse_count(input int exp_hi, input string tag);
    int hi;
    bit first;
    hi = 0;
    for (int i = 0; i < 12; i++) begin
      if (i == 0) first = ir_o;
      if (ir_o) hi++;
      @(negedge clk);
    end
    check({tag, " first"}, first, 1'b1);
    total++;
    if (hi != exp_hi) begin
      bad++;
      $display("FAIL %s: high count=%0d expected=%0d", tag, hi, exp_hi);
    end
    // period: the next period begins high again
    check("R2 next period", ir_o, 1'b1);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: done=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1402));
    repeat (3) @(negedge clk);
    check("R1 in reset", ir_o, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 after reset", ir_o, 1'b0);

    // R8: control cleared by reset -> latch 1 gives steady high
    wr_lat(1'b1);
    for (int i = 0; i < 14; i++) begin
      check("R8 steady", ir_o, 1'b1);
      @(negedge clk);
    end
    wr_lat(1'b0);
    check("R6 latch low", ir_o, 1'b0);

    // R4 / R7: third duty, rise mid-period gives full pulse
    wr_ctl(4'b0100);
    repeat (5) @(negedge clk);
    out_we = 1'b1; out_d = 1'b1;
    @(negedge clk); out_we = 1'b0;
    pulse_count(4, "R7 R4 third");

    // R3: half duty
    wr_lat(1'b0);
    wr_ctl(4'b1100);
    repeat (7) @(negedge clk);
    out_we = 1'b1; out_d = 1'b1;
    @(negedge clk); out_we = 1'b0;
    pulse_count(6, "R7 R3 half");

    // R9: repeat latch write mid-pulse keeps phase (2 cycles in, 4 more highs)
    @(negedge clk); @(negedge clk);
    out_we = 1'b1; out_d = 1'b1;
    @(negedge clk); out_we = 1'b0;
    check_model();
    for (int i = 0; i < 3; i++) begin @(negedge clk); check_model(); end
    @(negedge clk);
    check("R9 no restart", ir_o, 1'b0);

    // R10/R9: duty change mid-period applies to running count
    while (m_phase != 4) @(negedge clk);
    check("R10 half at phase4", ir_o, 1'b1);
    ctl_we = 1'b1; ctl_wd = 4'b0100;
    @(negedge clk); ctl_we = 1'b0;
    check("R10 third at phase5", ir_o, 1'b0);

    // R6: latch 0 with every control value
    wr_lat(1'b0);
    for (int v = 0; v < 16; v++) begin
      ctl_we = 1'b1; ctl_wd = 4'(v);
      @(negedge clk); ctl_we = 1'b0;
      check("R6 forced low", ir_o, 1'b0);
    end

    // random mix
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      check_model();
      ctl_we = ($urandom_range(0, 99) < 3);
      ctl_wd = 4'($urandom_range(0, 15));
      out_we = ($urandom_range(0, 99) < 4);
      out_d  = ($urandom_range(0, 99) < 70);
    end
    @(negedge clk);
    ctl_we = 1'b0; out_we = 1'b0;
    for (int n = 0; n < 30; n++) begin @(negedge clk); check_model(); end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule